// File: doc/BRIEF.md
# Serial EEPROM Slave with Page Buffer

This block models a 256-byte serial EEPROM that answers on a two-wire I2C bus. SCL and SDA are sampled on the system clock, START and STOP conditions are recognised, and the slave drives SDA low through an open-drain enable. The device address is the fixed nibble 1010 followed by three strap bits, then the read/write bit (1 = read).

A write transfer carries one byte address and then data bytes. The data bytes collect in a 16-entry page buffer. The buffer is copied into the array in a single step when STOP arrives. A timed internal write cycle follows, and during it the slave ignores its own address so that a master can poll for completion. A write-protect input blocks programming. Reads return bytes from an address pointer that advances through the whole array. A read is either a plain read from the current pointer, or a selective read: a write that sets the pointer, followed by a repeated START.

All traffic crosses the block on the two bus wires, so the block has no valid/ready stream port. Flow control is the bus's own acknowledge bit: the slave accepts a byte by driving ACK, and the master stops a read by answering NACK.

Top module: `ee_i2c_slave`

## Requirements
- R1: A START followed by the address byte {1010, strap[2:0], rw} is acknowledged by driving SDA low during the ninth clock. Any other address gets no acknowledge, and the slave then leaves SDA released until the next START.
- R2: In a write transfer, the byte after the device address is acknowledged and loaded as the address pointer.
- R3: Each accepted data byte is acknowledged and placed at the pointer. Only the low 4 pointer bits then increment, and the upper 4 bits stay fixed. A 17th or later byte wraps to the page start and overwrites the earlier byte at that slot.
- R4: Buffered data reaches the array only at STOP, with all bytes in one step. A repeated START discards the buffer.
- R5: After a STOP that ends a write holding at least one accepted data byte, `busy` is high for exactly WR_CYCLES clocks. While `busy` is high, the device address is not acknowledged. Once `busy` is low, it is acknowledged again.
- R6: With `wp` high, the device address and byte address are still acknowledged. The first data byte gets no acknowledge, the rest of the transfer is ignored, and the array keeps its contents.
- R7: A read returns the byte at the pointer and then increments the pointer across all 8 bits, so address 255 is followed by address 0. A plain read therefore continues one past the last byte accessed.
- R8: In a read, each master ACK makes the slave send the next byte, MSB first. After a master NACK the slave keeps SDA released until STOP or START.
- R9: After reset, `sda_oe` and `busy` are low and every array byte reads 8'hFF.
- R10: The slave changes its SDA drive only while SCL is low, and it releases SDA after a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| strap | input | 3 | Low three bits of the device address |
| wp | input | 1 | Write protect, high blocks programming |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| busy | output | 1 | High during the internal write cycle |

## Verification
Writes are tried in three shapes:
- A single byte, which shows the pointer load and the commit.
- A full 16-byte page starting mid-page, which shows the low-nibble wrap within one page.
- An 18-byte burst, which separates overwrite-at-page-start from spilling into the next page.

A data byte followed by a repeated START and a read-back of the old value distinguishes commit-at-STOP from commit-per-byte. With `wp` high, the byte address must still be acknowledged while the data bytes are refused, and the array must stay unchanged. Sequential reads that run across the 255-to-0 boundary, followed by a plain read, show that the pointer advances over all 8 bits rather than within a page. An extra byte clocked after a master NACK, with SDA expected to stay high, shows that the slave releases the bus.

// File: rtl/ee_pkg.sv
package ee_pkg;
  localparam logic [3:0] DEV_NIBBLE = 4'b1010;

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DACK, S_ADDR, S_AACK,
    S_WDAT, S_WACK, S_RDAT, S_RACK, S_WAIT
  } ee_state_e;
endpackage

// File: rtl/ee_bus_sync.sv
module ee_bus_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_q  <= scl_ff[1];
      sda_q  <= sda_ff[1];
    end
  end

  assign scl_s    = scl_ff[1];
  assign sda_s    = sda_ff[1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/ee_page_array.sv
module ee_page_array #(
  parameter int AW = 8,
  parameter int PW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          clr,
  input  logic          commit,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          any_valid
);
  localparam int DEPTH = 1 << AW;
  localparam int SLOTS = 1 << PW;

  logic [DW-1:0]    mem [DEPTH];
  logic [DW-1:0]    slot_d [SLOTS];
  logic [SLOTS-1:0] slot_v;
  logic [AW-PW-1:0] page;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) page <= '0;
    else if (wr_en) page <= wr_addr[AW-1:PW];
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_v[g] <= 1'b0;
        slot_d[g] <= '0;
      end else if (clr || commit) begin
        slot_v[g] <= 1'b0;
      end else if (wr_en && wr_addr[PW-1:0] == PW'(g)) begin
        slot_v[g] <= 1'b1;
        slot_d[g] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (commit) begin
      for (int i = 0; i < SLOTS; i++)
        if (slot_v[i]) mem[{page, PW'(i)}] <= slot_d[i];
    end
  end

  assign rd_data   = mem[rd_addr];
  assign any_valid = |slot_v;
endmodule

// File: rtl/ee_wr_timer.sv
module ee_wr_timer #(
  parameter int WR_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic busy
);
  localparam int CW = $clog2(WR_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (kick)       cnt <= CW'(WR_CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/ee_i2c_slave.sv
module ee_i2c_slave #(
  parameter int AW        = 8,
  parameter int PW        = 4,
  parameter int WR_CYCLES = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap,
  input  logic       wp,
  output logic       sda_oe,
  output logic       busy
);
  import ee_pkg::*;

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  ee_state_e state;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg, tx;
  logic [AW-1:0] ptr;
  logic          rw, mack;
  logic [7:0]    rd_data;
  logic          any_valid, commit, wr_take, load_rd, byte_in;

  ee_bus_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  assign byte_in = scl_fall && (bitcnt == 4'd8);
  assign wr_take = !stop_ev && !start_ev && state == S_WDAT && byte_in && !wp;
  assign commit  = stop_ev && any_valid;
  assign load_rd = !stop_ev && !start_ev && scl_fall &&
                   ((state == S_DACK && rw) || (state == S_RACK && mack));

  ee_page_array #(.AW(AW), .PW(PW), .DW(8)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_take), .wr_addr(ptr), .wr_data(shreg),
    .clr(start_ev), .commit(commit), .rd_addr(ptr), .rd_data(rd_data),
    .any_valid(any_valid)
  );

  ee_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .kick(commit), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      tx     <= '0;
      ptr    <= '0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_ev) begin
      state  <= S_IDLE;
      sda_oe <= 1'b0;
    end else if (start_ev) begin
      state  <= S_DEV;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (load_rd) begin
      tx     <= rd_data;
      sda_oe <= ~rd_data[7];
      ptr    <= ptr + 1'b1;
      bitcnt <= '0;
      state  <= S_RDAT;
    end else begin
      case (state)
        S_DEV, S_ADDR, S_WDAT: begin
          if (scl_rise && bitcnt != 4'd8) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_in) begin
            bitcnt <= '0;
            if (state == S_DEV) begin
              if (shreg[7:1] == {DEV_NIBBLE, strap} && !busy) begin
                sda_oe <= 1'b1;
                rw     <= shreg[0];
                state  <= S_DACK;
              end else begin
                state  <= S_IDLE;
              end
            end else if (state == S_ADDR) begin
              sda_oe <= 1'b1;
              ptr    <= shreg[AW-1:0];
              state  <= S_AACK;
            end else if (wp) begin
              state  <= S_WAIT;
            end else begin
              sda_oe <= 1'b1;
              ptr[PW-1:0] <= ptr[PW-1:0] + 1'b1;
              state  <= S_WACK;
            end
          end
        end
        S_DACK, S_AACK, S_WACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            state  <= (state == S_DACK) ? S_ADDR : S_WDAT;
          end
        end
        S_RDAT: begin
          if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              sda_oe <= 1'b0;
              state  <= S_RACK;
            end else begin
              tx     <= {tx[6:0], 1'b0};
              sda_oe <= ~tx[6];
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        S_RACK: begin
          if (scl_rise) mack <= ~sda_s;
          else if (scl_fall) state <= S_WAIT;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ee_i2c_chk.sv
module ee_i2c_chk #(
  parameter int AW        = 8,
  parameter int WR_CYCLES = 5000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          sda_oe,
  input logic          scl_s,
  input logic          stop_ev,
  input logic          wr_take,
  input logic [AW-1:0] ptr
);
  int unsigned run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run <= 0;
    else if (busy) run <= run + 1;
    else           run <= 0;
  end

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run < WR_CYCLES);

  // R5
  busy_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_ev));

  // R10
  drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);

  // R3
  page_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> ptr[AW-1:4] == $past(ptr[AW-1:4]));
endmodule

bind ee_i2c_slave ee_i2c_chk #(.AW(AW), .WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sda_oe(sda_oe), .scl_s(scl_s),
  .stop_ev(stop_ev), .wr_take(wr_take), .ptr(ptr)
);

// File: tb/ee_i2c_slave_bench.sv
module ee_i2c_slave_bench;
  localparam int WR = 300;
  localparam int Q  = 6;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe, busy;
  wire  sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  ee_i2c_slave #(.WR_CYCLES(WR)) u_ee_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap(STRAP), .wp(wp), .sda_oe(sda_oe), .busy(busy)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] mem_m [256];
  int ptr_m = 0;
  bit busy_ok = 0;
  int run = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // busy monitor on every clock (R5)
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (busy) begin
        run++;
        if (!busy_ok) check(0, "R5 busy without commit", 1, 0);
      end else if (run != 0) begin
        check(run == WR, "R5 busy length", run, WR);
        run = 0;
        busy_ok = 0;
      end
    end
    if (cyc > 150000) begin
      check(0, "watchdog", cyc, 150000);
      finish_run();
    end
  end

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    sda_m = b; wait_q();
    scl_m = 1'b1; wait_q();
    seen = sda_line; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
    clk_bit(1'b1, s);
    acked = ~s;
  endtask

  task automatic send_exp(input logic [7:0] v, input logic exp_ack, input string req);
    logic a;
    send_byte(v, a);
    check(a == exp_ack, req, a, exp_ack);
  endtask

  task automatic recv_exp(input logic [7:0] exp, input logic mack, input string req);
    logic s;
    logic [7:0] got = '0;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, s);
      got = {got[6:0], s};
    end
    clk_bit(~mack, s);
    check(got == exp, req, got, exp);
  endtask

  task automatic write_burst(input int addr, input int n, input int seed, input string req);
    logic [7:0] bufd [16];
    bit bufv [16];
    logic [7:0] d;
    for (int i = 0; i < 16; i++) bufv[i] = 0;
    bus_start();
    send_exp({4'b1010, STRAP, 1'b0}, 1'b1, "R1 device ack");
    send_exp(8'(addr), 1'b1, "R2 byte address ack");
    ptr_m = addr;
    for (int i = 0; i < n; i++) begin
      d = 8'(seed + i * 7);
      send_exp(d, 1'b1, req);
      bufd[ptr_m % 16] = d;
      bufv[ptr_m % 16] = 1;
      ptr_m = (ptr_m & 8'hF0) | ((ptr_m + 1) & 8'h0F);
    end
    if (n > 0) busy_ok = 1;
    bus_stop();
    for (int i = 0; i < 16; i++)
      if (bufv[i]) mem_m[(addr & 8'hF0) | i] = bufd[i];
  endtask

  task automatic poll_ready();
    logic a;
    int polls = 0;
    do begin
      bus_start();
      send_byte({4'b1010, STRAP, 1'b0}, a);
      bus_stop();
      if (polls == 0) check(!a, "R5 nack while busy", a, 0);
      polls++;
    end while (!a && polls < 20);
    check(a, "R5 ack after write cycle", a, 1);
  endtask

  task automatic read_cur(input int n, input string req);
    bus_start();
    send_exp({4'b1010, STRAP, 1'b1}, 1'b1, "R1 read address ack");
    for (int i = 0; i < n; i++) begin
      recv_exp(mem_m[ptr_m], i < n - 1, req);
      ptr_m = (ptr_m + 1) % 256;
    end
    bus_stop();
  endtask

  task automatic read_sel(input int addr, input int n, input string req);
    bus_start();
    send_exp({4'b1010, STRAP, 1'b0}, 1'b1, "R1 device ack");
    send_exp(8'(addr), 1'b1, "R2 byte address ack");
    ptr_m = addr;
    read_cur(n, req);
  endtask

  initial begin
    logic a;
    for (int i = 0; i < 256; i++) mem_m[i] = 8'hFF;
    repeat (4) @(negedge clk);
    check(sda_oe == 1'b0, "R9 sda_oe after reset", sda_oe, 0);
    check(busy == 1'b0, "R9 busy after reset", busy, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: wrong strap, then a following byte is ignored
    bus_start();
    send_exp({4'b1010, 3'b010, 1'b0}, 1'b0, "R1 foreign address nack");
    send_exp(8'h00, 1'b0, "R1 ignored until start");
    bus_stop();

    // R9: array erased
    read_sel(8'h10, 1, "R9 erased byte");

    // single byte write, pointer and plain read (R2, R7)
    write_burst(8'h10, 1, 8'h3C, "R3 data ack");
    poll_ready();
    read_cur(1, "R7 current read after write");
    read_sel(8'h10, 1, "R2 written byte");

    // full page starting mid-page (R3)
    write_burst(8'h24, 16, 8'h51, "R3 page data ack");
    poll_ready();
    read_sel(8'h20, 16, "R8 sequential page read");
    recv_exp(8'hFF, 1'b0, "R8 released after nack");
    bus_stop();

    // overrun wrap inside page (R3)
    write_burst(8'h33, 18, 8'h90, "R3 burst data ack");
    poll_ready();
    read_sel(8'h30, 17, "R3 wrapped page contents");

    // R4: repeated START discards buffered byte
    bus_start();
    send_exp({4'b1010, STRAP, 1'b0}, 1'b1, "R1 device ack");
    send_exp(8'h50, 1'b1, "R2 byte address ack");
    send_exp(8'hAA, 1'b1, "R4 data ack");
    bus_start();
    send_exp({4'b1010, STRAP, 1'b0}, 1'b1, "R4 not busy after restart");
    send_exp(8'h50, 1'b1, "R2 byte address ack");
    ptr_m = 8'h50;
    bus_start();
    send_exp({4'b1010, STRAP, 1'b1}, 1'b1, "R1 read address ack");
    recv_exp(mem_m[8'h50], 1'b0, "R4 no commit before stop");
    ptr_m = 8'h51;
    bus_stop();
    repeat (20) @(negedge clk);
    check(busy == 1'b0, "R4 no write cycle", busy, 0);

    // R6: write protect
    wp = 1'b1;
    bus_start();
    send_exp({4'b1010, STRAP, 1'b0}, 1'b1, "R6 device ack with wp");
    send_exp(8'h64, 1'b1, "R6 byte address ack with wp");
    send_exp(8'h12, 1'b0, "R6 first data nack");
    send_exp(8'h34, 1'b0, "R6 rest ignored");
    bus_stop();
    repeat (20) @(negedge clk);
    check(busy == 1'b0, "R6 no write cycle", busy, 0);
    wp = 1'b0;
    read_sel(8'h64, 1, "R6 array unchanged");

    // R7: pointer wrap 255 -> 0
    write_burst(8'hFE, 2, 8'h21, "R3 data ack");
    poll_ready();
    write_burst(8'h00, 2, 8'h77, "R3 data ack");
    poll_ready();
    read_sel(8'hFE, 3, "R7 read across top");
    read_cur(1, "R7 current read after wrap");

    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, a);
    bus_stop();
    check(a, "R5 idle device acks", a, 1);

    finish_run();
  end
endmodule